// File: doc/BRIEF.md
# Analog-Shared Digital I/O Port

This block is a 16-pin general-purpose digital I/O port whose pins double as inputs of an analog converter. Software reaches it through a byte-wide register bus with an address, a write strobe, write data and registered read data. It holds a direction register and an output latch. It also offers two read-only views of the pins: a pure input-status view, and a data view that mixes latched outputs with sampled inputs.

The converter block supplies one digital-input-enable bit per pin. When a pin's enable bit is 0, its digital input buffer is off. Every read path then reports that pin as logic 1, whatever level the pad carries. Pad inputs are resynchronised by two flops before any read path uses them. The block drives the pad output level and the pad output enable directly from its registers.

The map uses three register pairs and one reserved pair. The even address of each pair carries pins 15:8 and the odd address carries pins 7:0.

| Address | Register |
|---|---|
| 0 / 1 | port data (read view, write goes to the output latch) |
| 2 / 3 | direction |
| 4 / 5 | input status (read-only) |
| 6 / 7 | reserved |

There is no state machine. The port is a set of registers with a read multiplexer, so the brief names no states or transitions.

Top module: `gpio_ad_port`

## Requirements
- R1: Reset clears the direction register and the output latch, so pad_oe and pad_out are 0x0000. A read of the data view then returns 0xFF for each byte whose enable bits are 0.
- R2: The direction register is read and written at address 2 (pins 15:8) and address 3 (pins 7:0). A written value reads back unchanged. A direction bit of 1 means output and 0 means input.
- R3: pad_oe for each pin equals its direction bit, and pad_out equals its output latch bit, from the cycle after the write onward.
- R4: A write to address 0 (pins 15:8) or address 1 (pins 7:0) loads the output latch whatever the direction setting. The value appears on pad_out at once. A data-view read of a pin that is still an input does not show the latch.
- R5: The input-status view at address 4 (pins 15:8) and address 5 (pins 7:0) returns 1 for each pin whose enable bit is 0. It returns the synchronised pad level for each pin whose enable bit is 1.
- R6: Writes to addresses 4 and 5 have no effect. The status view, the direction register and the output latch are unchanged.
- R7: In the data view, a pin with direction 0 returns its synchronised pad level if its enable bit is 1, and returns 1 if its enable bit is 0.
- R8: In the data view, a pin with direction 1 returns its output latch bit, not the pad level.
- R9: bus_rdata shows the addressed byte one clock after the address is presented. A pad level change shows in a read result three clock edges after it settles: two synchroniser edges and one read-register edge.
- R10: Addresses 6 and 7 read as 0x00. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte address |
| bus_we | input | 1 | Write strobe for the addressed byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data of the byte addressed in the previous cycle |
| din_en | input | 16 | Per-pin digital input buffer enable from the converter |
| pad_in | input | 16 | Pad input levels (asynchronous) |
| pad_out | output | 16 | Pad output levels (output latch) |
| pad_oe | output | 16 | Pad output enables (direction register) |

## Verification
The bench targets the forced-one rule. It reads pins with their enables off while the pads are held low, so a design that leaked the pad level would return zeros where ones are due. It mixes input and output pins within one byte of the data view, which catches a design that returns the pad level for output pins or the latch for input pins. It writes the status and reserved addresses and then reads back the direction register and the output latch, to expose decoding that aliases those addresses. It also measures the exact three-edge latency from a pad change to the read result, which shows up a design that drops a synchroniser stage or adds one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NBYTES  = PORT_W / BYTE_W;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA_HI = 3'd0,
        SEL_DATA_LO = 3'd1,
        SEL_DIR_HI  = 3'd2,
        SEL_DIR_LO  = 3'd3,
        SEL_STAT_HI = 3'd4,
        SEL_STAT_LO = 3'd5,
        SEL_RSV_HI  = 3'd6,
        SEL_RSV_LO  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d_async[i]};
        end
        assign q_sync[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] latch_q
);
    // Byte b of a pair sits at offset NBYTES-1-b: the even offset holds the high byte.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam logic OFS = 1'(NBYTES - 1 - b);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dir_q[b*BYTE_W +: BYTE_W]   <= '0;
                latch_q[b*BYTE_W +: BYTE_W] <= '0;
            end else if (we && (sel[0] == OFS)) begin
                unique case (sel[ADDR_W-1:1])
                    2'd0: latch_q[b*BYTE_W +: BYTE_W] <= wdata;
                    2'd1: dir_q[b*BYTE_W +: BYTE_W]   <= wdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] pin_sync,
    input  logic [PORT_W-1:0] din_en,
    output logic [BYTE_W-1:0] rdata
);
    logic [PORT_W-1:0] stat_view;
    logic [PORT_W-1:0] data_view;
    logic [BYTE_W-1:0] rd_next;

    always_comb begin
        stat_view = pin_sync | ~din_en;
        data_view = (dir_q & latch_q) | (~dir_q & stat_view);
    end

    always_comb begin
        unique case (sel)
            SEL_DATA_HI: rd_next = data_view[PORT_W-1 -: BYTE_W];
            SEL_DATA_LO: rd_next = data_view[BYTE_W-1:0];
            SEL_DIR_HI:  rd_next = dir_q[PORT_W-1 -: BYTE_W];
            SEL_DIR_LO:  rd_next = dir_q[BYTE_W-1:0];
            SEL_STAT_HI: rd_next = stat_view[PORT_W-1 -: BYTE_W];
            SEL_STAT_LO: rd_next = stat_view[BYTE_W-1:0];
            SEL_RSV_HI,
            SEL_RSV_LO:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_next;
    end
endmodule

// File: rtl/gpio_ad_port.sv
module gpio_ad_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] din_en,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);
    reg_sel_e          sel;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] pin_sync;

    assign sel = reg_sel_e'(bus_addr);

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(pin_sync)
    );

    gpio_regs i_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .we(bus_we), .wdata(bus_wdata),
        .dir_q(dir_q), .latch_q(latch_q)
    );

    gpio_rdmux i_rdmux (
        .clk(clk), .rst_n(rst_n), .sel(sel), .dir_q(dir_q), .latch_q(latch_q),
        .pin_sync(pin_sync), .din_en(din_en), .rdata(bus_rdata)
    );

    assign pad_oe  = dir_q;
    assign pad_out = latch_q;
endmodule

// File: rtl/gpio_ad_port_chk.sv
module gpio_ad_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_addr,
    input logic        bus_we,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [15:0] din_en,
    input logic [15:0] pad_out,
    input logic [15:0] pad_oe
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == 16'h0000 && pad_out == 16'h0000));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd2) |=> pad_oe[15:8] == $past(bus_wdata));

    assert_latch_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd1) |=> pad_out[7:0] == $past(bus_wdata));

    assert_stat_hi_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && bus_addr == 3'd4 && din_en[15:8] == 8'h00) |=> bus_rdata == 8'hFF);

    assert_stat_lo_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && bus_addr == 3'd5 && din_en[7:0] == 8'h00) |=> bus_rdata == 8'hFF);

    assert_stat_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == 3'd4 || bus_addr == 3'd5)) |=> ($stable(pad_oe) && $stable(pad_out)));

    assert_out_pin_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd1 && pad_oe[7:0] == 8'hFF) |=> bus_rdata == $past(pad_out[7:0]));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[2:1] == 2'b11) |=> bus_rdata == 8'h00);
endmodule

bind gpio_ad_port gpio_ad_port_chk i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din_en(din_en),
    .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_gpio_ad_port.sv
module test_gpio_ad_port;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;

    // {req[3:0], chk, we, addr[2:0], wdata[7:0], en[15:0], pad[15:0], exp[7:0]}
    localparam logic [56:0] VEC [NVEC] = '{
        {4'd1,  1'b1, 1'b0, 3'd0, 8'h00, 16'h0000, 16'h0000, 8'hFF}, // R1 forced ones
        {4'd1,  1'b1, 1'b0, 3'd2, 8'h00, 16'h0000, 16'h0000, 8'h00}, // R1 dir cleared
        {4'd5,  1'b1, 1'b0, 3'd4, 8'h00, 16'hFFFF, 16'hA55A, 8'hA5}, // R5 live hi
        {4'd5,  1'b1, 1'b0, 3'd5, 8'h00, 16'hFFFF, 16'hA55A, 8'h5A}, // R5 live lo
        {4'd5,  1'b1, 1'b0, 3'd5, 8'h00, 16'h00F0, 16'h0000, 8'h0F}, // R5 mixed enables
        {4'd7,  1'b1, 1'b0, 3'd1, 8'h00, 16'hFFFF, 16'h003C, 8'h3C}, // R7 input pins
        {4'd4,  1'b0, 1'b1, 3'd1, 8'hC3, 16'hFFFF, 16'h003C, 8'h00}, // R4 latch lo while input
        {4'd4,  1'b1, 1'b0, 3'd1, 8'h00, 16'hFFFF, 16'h003C, 8'h3C}, // R4 latch hidden
        {4'd2,  1'b0, 1'b1, 3'd3, 8'h0F, 16'hFFFF, 16'h0000, 8'h00}, // R2 dir lo
        {4'd8,  1'b1, 1'b0, 3'd1, 8'h00, 16'hFFFF, 16'h0000, 8'h03}, // R8 mixed byte
        {4'd2,  1'b1, 1'b0, 3'd3, 8'h00, 16'hFFFF, 16'h0000, 8'h0F}, // R2 readback lo
        {4'd2,  1'b0, 1'b1, 3'd2, 8'h81, 16'hFFFF, 16'h0000, 8'h00}, // R2 dir hi
        {4'd2,  1'b1, 1'b0, 3'd2, 8'h00, 16'hFFFF, 16'h0000, 8'h81}, // R2 readback hi
        {4'd8,  1'b0, 1'b1, 3'd0, 8'h00, 16'hFFFF, 16'hFFFF, 8'h00}, // R8 latch hi = 0
        {4'd8,  1'b1, 1'b0, 3'd0, 8'h00, 16'hFFFF, 16'hFFFF, 8'h7E}, // R8 pad ignored on outputs
        {4'd6,  1'b0, 1'b1, 3'd4, 8'h00, 16'h0000, 16'h0000, 8'h00}, // R6 write status
        {4'd6,  1'b1, 1'b0, 3'd4, 8'h00, 16'h0000, 16'h0000, 8'hFF}, // R6 status unchanged
        {4'd6,  1'b1, 1'b0, 3'd2, 8'h00, 16'h0000, 16'h0000, 8'h81}, // R6 dir unchanged
        {4'd10, 1'b0, 1'b1, 3'd6, 8'hAA, 16'hFFFF, 16'hFFFF, 8'h00}, // R10 write reserved
        {4'd10, 1'b1, 1'b0, 3'd6, 8'h00, 16'hFFFF, 16'hFFFF, 8'h00}, // R10 reads zero
        {4'd10, 1'b1, 1'b0, 3'd7, 8'h00, 16'hFFFF, 16'hFFFF, 8'h00}, // R10 reads zero
        {4'd10, 1'b1, 1'b0, 3'd0, 8'h00, 16'hFFFF, 16'hFFFF, 8'h7E}, // R10 latch unchanged
        {4'd7,  1'b1, 1'b0, 3'd0, 8'h00, 16'h0000, 16'h0000, 8'h7E}  // R7 disabled inputs = 1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd7;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [15:0] din_en = 16'h0000;
    logic [15:0] pad_in = 16'h0000;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_ad_port i_gpio_ad_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din_en(din_en),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = 3'd7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive one access at a negedge; read result is sampled at the following negedge.
    task automatic access(input logic we, input logic [2:0] a, input logic [7:0] wd);
        bus_we = we; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 3'd7;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();
        check("R1 pad_oe after reset", pad_oe, 16'h0000);
        check("R1 pad_out after reset", pad_out, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            logic [56:0] v;
            v = VEC[i];
            din_en = v[39:24];
            pad_in = v[23:8];
            repeat (3) @(negedge clk);
            access(v[51], v[50:48], v[47:40]);
            if (v[52])
                check($sformatf("R%0d vector %0d", v[56:53], i), {8'h00, bus_rdata}, {8'h00, v[7:0]});
        end

        check("R3 pad_oe follows direction", pad_oe, 16'h810F);
        check("R3 pad_out follows latch", pad_out, 16'h00C3);

        // R9: exact latency of a pad change through synchroniser and read register
        din_en = 16'hFFFF; pad_in = 16'h0000;
        bus_addr = 3'd5; bus_we = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 status before change", {8'h00, bus_rdata}, 16'h0000);
        pad_in = 16'h0055;
        @(negedge clk);
        check("R9 one edge after change", {8'h00, bus_rdata}, 16'h0000);
        @(negedge clk);
        check("R9 two edges after change", {8'h00, bus_rdata}, 16'h0000);
        @(negedge clk);
        check("R9 three edges after change", {8'h00, bus_rdata}, 16'h0055);
        bus_addr = 3'd7;
        @(negedge clk);

        // R4 and R3 from a fresh reset: latch visible on pads before direction is set
        do_reset();
        access(1'b1, 3'd1, 8'h5A);
        check("R4 pad_out after latch write", pad_out, 16'h005A);
        check("R4 pad_oe stays input", pad_oe, 16'h0000);
        access(1'b1, 3'd3, 8'hFF);
        check("R3 pad_oe after dir write", pad_oe, 16'h00FF);
        check("R3 pad_out held", pad_out, 16'h005A);
        access(1'b1, 3'd5, 8'h00);
        check("R6 pad_oe unchanged by status write", pad_oe, 16'h00FF);
        check("R6 pad_out unchanged by status write", pad_out, 16'h005A);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule